// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is a one-bit-wide read-only store that feeds a configuration bitstream to a loader, one bit per clock. It has no address bus. An internal address register starts at zero after reset and moves forward by one on each rising clock edge while the device is enabled. The bit at the current address is shown on the data output shortly after each edge. The contents are fixed. They come from a closed-form pattern computed from the address and a seed parameter, so no storage file is needed.

Several instances can form a chain. All of them share one clock and one data line. The chain-enable output of each device feeds the enable input of the next one. After a device has delivered its last bit, it releases the data line and raises its chain-enable output, so the next device drives bit 0 of its own contents in the following cycle. A single pin serves as both reset and output enable. Its active level is chosen by a parameter, and inside the block it becomes one active-high reset.

Top module: `scrom_serial`

## Requirements
- R1: While reset is active, the address returns to zero on the next rising edge, `data_oe_o` is 0 and `ceo_o` is 0.
- R2: With `RST_ACTIVE_HIGH`=1, a high level on `rst_oe_i` is the reset state. With `RST_ACTIVE_HIGH`=0, a low level is the reset state. The other level lets the device run.
- R3: The first clock cycle after reset is released, with `ce_i` high, shows the content bit of address 0 on `data_o` with `data_oe_o` at 1.
- R4: Each rising edge taken while the device is enabled and not finished advances the address by exactly one. The content bit at address a is the parity of the low AW bits of ((3·a) XOR SEED), where AW = clog2(DEPTH).
- R5: While `ce_i` is low, the address holds its value and both `data_oe_o` and `ceo_o` are 0. When `ce_i` rises again, streaming resumes at the held address.
- R6: The rising edge taken at address DEPTH−1 finishes the device. After that edge the address no longer moves, `data_oe_o` stays 0, and `ceo_o` is 1 while `ce_i` is high. `data_oe_o` and `ceo_o` are never 1 together.
- R7: `ceo_o` is 1 only when `ce_i` is high and reset is not active.
- R8: In a chain of two devices that share clock, reset and data, the bits on the shared line are the full contents of the first device followed directly by the full contents of the second. Only one device drives the line at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock; the address advances on its rising edge |
| rst_oe_i | input | 1 | Combined reset / output-enable pin; its active level is set by `RST_ACTIVE_HIGH` |
| ce_i | input | 1 | Chip enable, active high; driven by the previous device's `ceo_o` in a chain |
| data_o | output | 1 | Serial data; high impedance when the device is not driving |
| data_oe_o | output | 1 | High while the device drives `data_o` |
| ceo_o | output | 1 | Chain-enable output, high once all contents have been delivered |

## Verification
The bench concentrates on the handover at the terminal count. A design that is one cycle late would leave a gap bit or repeat a bit on the shared line. A design that is early would drop the last bit, or let both devices drive in the same cycle. It pauses the enable both before the first bit and in the middle of the stream. A counter that kept running while disabled would skip bits on resume, and one that lost its place would restart from zero. Each chain is also run with the opposite reset polarity and is reset part-way through. An inverted polarity would keep the device silent or make it ignore reset. A reset that only gated the outputs would resume from the old address instead of from bit 0.

// File: rtl/scrom_pkg.sv
package scrom_pkg;

    // Coarse activity of one device in the current cycle.
    typedef enum logic [1:0] {
        PH_RESET  = 2'd0,
        PH_PAUSED = 2'd1,
        PH_STREAM = 2'd2,
        PH_SPENT  = 2'd3
    } phase_e;

    // Fixed content: parity of the low aw bits of (3*a) ^ seed.
    function automatic logic pattern_bit(input logic [31:0] a,
                                         input logic [31:0] seed,
                                         input int unsigned aw);
        logic [31:0] v;
        logic        r;
        v = (a * 32'd3) ^ seed;
        r = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(aw)) r = r ^ v[i];
        end
        return r;
    endfunction

    // Priority: reset, then enable, then finished, then streaming.
    function automatic phase_e decode_phase(input logic rst_act,
                                            input logic ce,
                                            input logic spent);
        if (rst_act)    return PH_RESET;
        else if (!ce)   return PH_PAUSED;
        else if (spent) return PH_SPENT;
        else            return PH_STREAM;
    endfunction

endpackage

// File: rtl/scrom_rst_sense.sv
module scrom_rst_sense #(
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic pin_i,
    output logic rst_act_o
);
    generate
        if (RST_ACTIVE_HIGH) begin : g_high
            assign rst_act_o = pin_i;
        end else begin : g_low
            assign rst_act_o = ~pin_i;
        end
    endgenerate
endmodule

// File: rtl/scrom_addr_seq.sv
module scrom_addr_seq #(
    parameter int unsigned DEPTH = 262144,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_act_i,
    input  logic          ce_i,
    output logic [AW-1:0] addr_o,
    output logic          spent_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          spent;
    } seq_t;

    seq_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (ce_i && !cur_q.spent) begin
            if (cur_q.addr == LAST) nxt.spent = 1'b1;
            else                    nxt.addr  = cur_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_act_i) cur_q <= '0;
        else           cur_q <= nxt;
    end

    assign addr_o  = cur_q.addr;
    assign spent_o = cur_q.spent;
endmodule

// File: rtl/scrom_bit_source.sv
module scrom_bit_source #(
    parameter int unsigned DEPTH = 262144,
    parameter logic [31:0] SEED  = 32'h0000_005A,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output logic          bit_o
);
    import scrom_pkg::*;
    assign bit_o = pattern_bit(32'(addr_i), SEED, AW);
endmodule

// File: rtl/scrom_drive.sv
module scrom_drive (
    input  scrom_pkg::phase_e phase_i,
    input  logic              bit_i,
    output logic              data_o,
    output logic              data_oe_o,
    output logic              ceo_o
);
    import scrom_pkg::*;
    assign data_oe_o = (phase_i == PH_STREAM);
    assign ceo_o     = (phase_i == PH_SPENT);
    assign data_o    = data_oe_o ? bit_i : 1'bz;
endmodule

// File: rtl/scrom_serial.sv
module scrom_serial #(
    parameter int unsigned DEPTH           = 262144,
    parameter logic [31:0] SEED            = 32'h0000_005A,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    localparam int unsigned AW             = $clog2(DEPTH)
) (
    input  logic clk_i,
    input  logic rst_oe_i,
    input  logic ce_i,
    output logic data_o,
    output logic data_oe_o,
    output logic ceo_o
);
    import scrom_pkg::*;

    logic          rst_act;
    logic [AW-1:0] cur_addr;
    logic          spent;
    logic          cell_bit;
    phase_e        phase;

    scrom_rst_sense #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_rst (
        .pin_i     (rst_oe_i),
        .rst_act_o (rst_act)
    );

    scrom_addr_seq #(.DEPTH(DEPTH)) u_seq (
        .clk_i     (clk_i),
        .rst_act_i (rst_act),
        .ce_i      (ce_i),
        .addr_o    (cur_addr),
        .spent_o   (spent)
    );

    scrom_bit_source #(.DEPTH(DEPTH), .SEED(SEED)) u_cells (
        .addr_i (cur_addr),
        .bit_o  (cell_bit)
    );

    assign phase = decode_phase(rst_act, ce_i, spent);

    scrom_drive u_drv (
        .phase_i   (phase),
        .bit_i     (cell_bit),
        .data_o    (data_o),
        .data_oe_o (data_oe_o),
        .ceo_o     (ceo_o)
    );
endmodule

// File: rtl/scrom_serial_chk.sv
module scrom_serial_chk #(
    parameter int unsigned DEPTH           = 262144,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    localparam int unsigned AW             = $clog2(DEPTH)
) (
    input logic          clk_i,
    input logic          rst_oe_i,
    input logic          ce_i,
    input logic          data_oe_o,
    input logic          ceo_o,
    input logic [AW-1:0] cur_addr,
    input logic          spent
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    logic in_rst;
    assign in_rst = RST_ACTIVE_HIGH ? rst_oe_i : !rst_oe_i;

    p_reset_clears_r1: assert property (@(posedge clk_i)
        in_rst |=> (cur_addr == '0 && !spent));

    p_quiet_in_reset_r1: assert property (@(posedge clk_i)
        in_rst |-> (!data_oe_o && !ceo_o));

    p_advance_r4: assert property (@(posedge clk_i) disable iff (in_rst)
        (ce_i && !spent && cur_addr != LAST) |=> (cur_addr == $past(cur_addr) + 1'b1));

    p_hold_when_off_r5: assert property (@(posedge clk_i) disable iff (in_rst)
        !ce_i |=> $stable(cur_addr));

    p_silent_when_off_r5: assert property (@(posedge clk_i)
        !ce_i |-> (!data_oe_o && !ceo_o));

    p_stop_at_end_r6: assert property (@(posedge clk_i) disable iff (in_rst)
        spent |=> (spent && $stable(cur_addr)));

    p_one_role_r6: assert property (@(posedge clk_i)
        !(data_oe_o && ceo_o));

    p_ceo_needs_ce_r7: assert property (@(posedge clk_i)
        ceo_o |-> ce_i);
endmodule

bind scrom_serial scrom_serial_chk #(
    .DEPTH(DEPTH),
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
    .clk_i     (clk_i),
    .rst_oe_i  (rst_oe_i),
    .ce_i      (ce_i),
    .data_oe_o (data_oe_o),
    .ceo_o     (ceo_o),
    .cur_addr  (cur_addr),
    .spent     (spent)
);

// File: tb/scrom_serial_tb_top.sv
module scrom_serial_tb_top;
    // chain 0: active-high reset; chain 1: active-low reset
    localparam int unsigned D00 = 8, D01 = 5, D10 = 6, D11 = 4;
    localparam logic [31:0] S00 = 32'd5, S01 = 32'd9, S10 = 32'd3, S11 = 32'd10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [1:0] rst_pin;
    logic [1:0] ce_in;
    wire  [1:0] d_a, d_b, oe_a, oe_b, ceo_a, ceo_b;

    int n_chk = 0;
    int n_bad = 0;

    scrom_serial #(.DEPTH(D00), .SEED(S00), .RST_ACTIVE_HIGH(1'b1)) dut_i (
        .clk_i(clk), .rst_oe_i(rst_pin[0]), .ce_i(ce_in[0]),
        .data_o(d_a[0]), .data_oe_o(oe_a[0]), .ceo_o(ceo_a[0]));
    scrom_serial #(.DEPTH(D01), .SEED(S01), .RST_ACTIVE_HIGH(1'b1)) dut_b (
        .clk_i(clk), .rst_oe_i(rst_pin[0]), .ce_i(ceo_a[0]),
        .data_o(d_b[0]), .data_oe_o(oe_b[0]), .ceo_o(ceo_b[0]));
    scrom_serial #(.DEPTH(D10), .SEED(S10), .RST_ACTIVE_HIGH(1'b0)) dut_c (
        .clk_i(clk), .rst_oe_i(rst_pin[1]), .ce_i(ce_in[1]),
        .data_o(d_a[1]), .data_oe_o(oe_a[1]), .ceo_o(ceo_a[1]));
    scrom_serial #(.DEPTH(D11), .SEED(S11), .RST_ACTIVE_HIGH(1'b0)) dut_d (
        .clk_i(clk), .rst_oe_i(rst_pin[1]), .ce_i(ceo_a[1]),
        .data_o(d_b[1]), .data_oe_o(oe_b[1]), .ceo_o(ceo_b[1]));

    // content as stated in R4
    function automatic logic exp_bit(input int unsigned depth, input logic [31:0] seed,
                                     input int unsigned a);
        int unsigned w;
        logic [31:0] m;
        w = $clog2(depth);
        m = (32'd1 << w) - 32'd1;
        return logic'($countones(((a * 3) ^ seed) & m) % 2);
    endfunction

    function automatic int unsigned dep(input int ch, input int dev);
        if (ch == 0) return (dev == 0) ? D00 : D01;
        return (dev == 0) ? D10 : D11;
    endfunction

    function automatic logic [31:0] sd(input int ch, input int dev);
        if (ch == 0) return (dev == 0) ? S00 : S01;
        return (dev == 0) ? S10 : S11;
    endfunction

    // pin level for reset asserted (act=1) or released (act=0), per R2
    function automatic logic lvl(input int ch, input logic act);
        return (ch == 0) ? act : ~act;
    endfunction

    task automatic check(input string req, input logic got, input logic want, input string what);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, want);
        end
    endtask

    task automatic edge_wait(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // reset the chain and leave it enabled, still in reset
    task automatic hold_reset(input int ch);
        rst_pin[ch] = lvl(ch, 1'b1);
        ce_in[ch]   = 1'b1;
        edge_wait(2);
    endtask

    task automatic t_reset_state(input int ch);
        hold_reset(ch);
        check("R1", oe_a[ch], 1'b0, "oe dev0 in reset");
        check("R1", oe_b[ch], 1'b0, "oe dev1 in reset");
        check("R1", ceo_a[ch], 1'b0, "ceo dev0 in reset");
        check("R2", ceo_b[ch], 1'b0, "ceo dev1 in reset");
    endtask

    // R3 R4 R6 R8: full chain stream on the shared line
    task automatic t_stream(input int ch);
        int unsigned a;
        int unsigned tot;
        logic line;
        hold_reset(ch);
        rst_pin[ch] = lvl(ch, 1'b0);
        #1;
        check("R2", oe_a[ch], 1'b1, "released level runs device");
        check("R3", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 0), "first bit");
        tot = dep(ch, 0) + dep(ch, 1);
        for (int k = 0; k < int'(tot); k++) begin
            if (k > 0) edge_wait(1);
            check("R8", logic'(oe_a[ch] & oe_b[ch]), 1'b0, "single driver");
            line = oe_a[ch] ? d_a[ch] : (oe_b[ch] ? d_b[ch] : 1'bx);
            if (k < int'(dep(ch, 0))) begin
                a = k;
                check("R4", line, exp_bit(dep(ch, 0), sd(ch, 0), a), $sformatf("dev0 bit %0d", a));
            end else begin
                a = k - dep(ch, 0);
                check("R8", line, exp_bit(dep(ch, 1), sd(ch, 1), a), $sformatf("dev1 bit %0d", a));
            end
        end
        edge_wait(1);
        check("R6", oe_a[ch], 1'b0, "dev0 released after end");
        check("R6", oe_b[ch], 1'b0, "dev1 released after end");
        check("R6", ceo_a[ch], 1'b1, "dev0 ceo after end");
        check("R6", ceo_b[ch], 1'b1, "dev1 ceo after end");
        edge_wait(3);
        check("R6", logic'(oe_a[ch] | oe_b[ch]), 1'b0, "still silent later");
    endtask

    // R5: pause before first bit and mid-stream
    task automatic t_pause(input int ch);
        hold_reset(ch);
        ce_in[ch]   = 1'b0;
        rst_pin[ch] = lvl(ch, 1'b0);
        edge_wait(3);
        check("R5", oe_a[ch], 1'b0, "no drive while ce low");
        check("R5", ceo_a[ch], 1'b0, "no ceo while ce low");
        ce_in[ch] = 1'b1;
        #1;
        check("R5", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 0), "bit0 after pause");
        edge_wait(2);
        check("R5", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 2), "bit2 before pause");
        ce_in[ch] = 1'b0;
        edge_wait(2);
        check("R5", oe_a[ch], 1'b0, "mid pause silent");
        ce_in[ch] = 1'b1;
        #1;
        check("R5", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 2), "resume at held addr");
        edge_wait(1);
        check("R4", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 3), "bit3 after resume");
    endtask

    // R7: ceo follows ce and reset
    task automatic t_ceo_gate(input int ch);
        hold_reset(ch);
        rst_pin[ch] = lvl(ch, 1'b0);
        edge_wait(dep(ch, 0));
        check("R6", ceo_a[ch], 1'b1, "ceo at handover");
        ce_in[ch] = 1'b0;
        #1;
        check("R7", ceo_a[ch], 1'b0, "ceo drops with ce");
        ce_in[ch] = 1'b1;
        #1;
        check("R7", ceo_a[ch], 1'b1, "ceo back with ce");
        rst_pin[ch] = lvl(ch, 1'b1);
        #1;
        check("R7", ceo_a[ch], 1'b0, "ceo drops in reset");
    endtask

    // R1: reset mid-stream restarts from address 0
    task automatic t_reset_mid(input int ch);
        hold_reset(ch);
        rst_pin[ch] = lvl(ch, 1'b0);
        edge_wait(4);
        rst_pin[ch] = lvl(ch, 1'b1);
        edge_wait(1);
        check("R1", oe_a[ch], 1'b0, "silent in mid reset");
        rst_pin[ch] = lvl(ch, 1'b0);
        #1;
        check("R1", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 0), "restart at bit0");
        edge_wait(1);
        check("R1", d_a[ch], exp_bit(dep(ch, 0), sd(ch, 0), 1), "then bit1");
    endtask

    initial begin
        rst_pin = 2'b01;   // both chains in reset
        ce_in   = 2'b00;
        for (int ch = 0; ch < 2; ch++) begin
            t_reset_state(ch);
            t_stream(ch);
            t_pause(ch);
            t_ceo_gate(ch);
            t_reset_mid(ch);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule